// File: doc/BRIEF.md
# Timer Interrupt Flag Register with Mode Qualification

This block holds the four pending-event flags of a timer/counter and turns them into interrupt requests. A timer core delivers single-cycle strobes for counter overflow, an 8-bit compare match on each of the two compare registers, a full 16-bit compare match, and a qualified capture event. The block latches these strobes into sticky flags. Software reads the flags as one 8-bit register and clears them by writing ones. A flag is also cleared when the interrupt controller acknowledges that flag's vector.

Whether a compare strobe may set its flag depends on the operating mode. When the two compare registers act as one 16-bit compare value, the B flag is blocked, and the A flag follows the 16-bit match strobe instead of the 8-bit A strobe. When the registers hold a 16-bit capture value, neither compare flag may set. The capture flag and the overflow flag respond in every mode.

Each source drives its own request line. A line is high only when the global enable, that source's enable bit and its flag are all set. All state resets synchronously. A set strobe arriving in the same cycle as a clear request wins, so no event is lost.

Top module: `timerFlags`

## Requirements
- R1: The read register places overflow at bit 0, compare A at bit 1, compare B at bit 2 and capture at bit 3. Bits 7 to 4 always read zero. After a synchronous reset every bit reads zero.
- R2: A bus write with a one in bits 3..0 clears the matching flag at the next clock edge. A zero in a bit leaves that flag unchanged, and bits 7..4 of the write data have no effect on the readback.
- R3: A high bit of `ackVec` (same bit order as R1) clears the matching flag at the next clock edge.
- R4: `ovfEvt` sets the overflow flag at the next clock edge, in every mode.
- R5: While `mode16Cmp` or `mode16Cap` is high, `cmpBEvt` never sets the compare B flag.
- R6: While `mode16Cmp` is high and `mode16Cap` is low, the compare A flag sets on `cmp16Evt`, and `cmpAEvt` is ignored. With both modes low, it sets on `cmpAEvt`, and `cmp16Evt` is ignored.
- R7: While `mode16Cap` is high, the compare A flag never sets, whatever the state of `mode16Cmp`.
- R8: `capEvt` sets the capture flag at the next clock edge, in every mode.
- R9: `irq[i]` is high exactly when `globalIe`, `intEnable[i]` and flag i are all high. It follows the flag and the enables with no added delay.
- R10: When a set event and a clear (write-one or acknowledge) target the same flag in the same cycle, the flag is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| ovfEvt | input | 1 | Counter overflow strobe |
| cmpAEvt | input | 1 | 8-bit match strobe on compare register A |
| cmpBEvt | input | 1 | 8-bit match strobe on compare register B |
| cmp16Evt | input | 1 | Full 16-bit match strobe (B high, A low) |
| capEvt | input | 1 | Qualified capture event strobe |
| mode16Cmp | input | 1 | 16-bit compare mode active |
| mode16Cap | input | 1 | 16-bit capture mode active |
| regWrEn | input | 1 | Bus write strobe to the flag register |
| regWrData | input | 8 | Bus write data, ones clear flags |
| regRdData | output | 8 | Flag register readback |
| ackVec | input | 4 | Per-flag vector acknowledge |
| intEnable | input | 4 | Per-source interrupt enable |
| globalIe | input | 1 | Global interrupt enable |
| irq | output | 4 | Per-source interrupt request |

## Verification
Strobes, writes and acknowledges applied before a clock edge show in `regRdData` right after that edge, one register stage later. The request lines depend only on the stored flags and the current enables, so they are due in the same cycle. The bench drives every input on the falling edge. It checks `irq` shortly afterwards against the flags it already expects. It then checks `regRdData` at the next falling edge against the value its model predicted from the inputs it drove, so no sample lands on the active edge.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
  // register geometry
  localparam int REG_W  = 8;
  localparam int FLAG_W = 4;

  // bit positions that software decodes
  localparam int BIT_OVF  = 0;
  localparam int BIT_CMPA = 1;
  localparam int BIT_CMPB = 2;
  localparam int BIT_CAP  = 3;

  typedef logic [FLAG_W-1:0] flagVec_t;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    flagVec_t setMask;
    flagVec_t clrMask;
  } flagCtl_t;
endpackage

// File: rtl/tflag_ctl.sv
module tflagCtl
  import tflag_pkg::*;
(
  input  logic             ovfEvt,
  input  logic             cmpAEvt,
  input  logic             cmpBEvt,
  input  logic             cmp16Evt,
  input  logic             capEvt,
  input  logic             mode16Cmp,
  input  logic             mode16Cap,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  flagVec_t         ackVec,
  output flagCtl_t         ctl
);
  logic cmpASet;
  logic cmpBSet;
  flagVec_t wrClr;

  // capture mode owns both compare registers, so it outranks 16-bit compare
  always_comb begin
    if (mode16Cap)      cmpASet = 1'b0;
    else if (mode16Cmp) cmpASet = cmp16Evt;
    else                cmpASet = cmpAEvt;
  end

  assign cmpBSet = cmpBEvt & ~mode16Cmp & ~mode16Cap;
  assign wrClr   = regWrEn ? regWrData[FLAG_W-1:0] : '0;

  always_comb begin
    ctl = '0;
    ctl.setMask[BIT_OVF]  = ovfEvt;
    ctl.setMask[BIT_CMPA] = cmpASet;
    ctl.setMask[BIT_CMPB] = cmpBSet;
    ctl.setMask[BIT_CAP]  = capEvt;
    ctl.clrMask           = wrClr | ackVec;
  end
endmodule

// File: rtl/tflag_dp.sv
module tflagDp
  import tflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  flagCtl_t         ctl,
  input  flagVec_t         intEnable,
  input  logic             globalIe,
  output logic [REG_W-1:0] regRdData,
  output flagVec_t         irq
);
  flagVec_t flagQ;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    // set has priority over any clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst)                 flagQ[i] <= 1'b0;
      else if (ctl.setMask[i]) flagQ[i] <= 1'b1;
      else if (ctl.clrMask[i]) flagQ[i] <= 1'b0;
    end
    assign irq[i] = globalIe & intEnable[i] & flagQ[i];
  end

  assign regRdData = {{(REG_W-FLAG_W){1'b0}}, flagQ};

  // R10: a set request is never lost to a concurrent clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ctl.setMask != '0) |=> ((flagQ & $past(ctl.setMask)) == $past(ctl.setMask)));

  // R2 R3: a clear with no set drops the flag
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
    ((ctl.clrMask & ~ctl.setMask) != '0) |=>
      ((flagQ & $past(ctl.clrMask & ~ctl.setMask)) == '0));
endmodule

// File: rtl/timerFlags.sv
module timerFlags
  import tflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ovfEvt,
  input  logic             cmpAEvt,
  input  logic             cmpBEvt,
  input  logic             cmp16Evt,
  input  logic             capEvt,
  input  logic             mode16Cmp,
  input  logic             mode16Cap,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic [3:0]       ackVec,
  input  logic [3:0]       intEnable,
  input  logic             globalIe,
  output logic [3:0]       irq
);
  flagCtl_t ctlStrb;

  tflagCtl ctl_i (
    .ovfEvt(ovfEvt), .cmpAEvt(cmpAEvt), .cmpBEvt(cmpBEvt),
    .cmp16Evt(cmp16Evt), .capEvt(capEvt),
    .mode16Cmp(mode16Cmp), .mode16Cap(mode16Cap),
    .regWrEn(regWrEn), .regWrData(regWrData), .ackVec(ackVec),
    .ctl(ctlStrb)
  );

  tflagDp dp_i (
    .clk(clk), .rst(rst), .ctl(ctlStrb),
    .intEnable(intEnable), .globalIe(globalIe),
    .regRdData(regRdData), .irq(irq)
  );

  // R4: overflow strobe lands in bit 0
  a_r4_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    ovfEvt |=> regRdData[BIT_OVF]);

  // R8: capture strobe lands in bit 3 in any mode
  a_r8_cap_sets: assert property (@(posedge clk) disable iff (rst)
    capEvt |=> regRdData[BIT_CAP]);

  // R5: compare B stays clear in either 16-bit mode
  a_r5_b_blocked: assert property (@(posedge clk) disable iff (rst)
    ((mode16Cmp || mode16Cap) && !regRdData[BIT_CMPB]) |=> !regRdData[BIT_CMPB]);

  // R7: compare A stays clear in capture mode
  a_r7_a_blocked: assert property (@(posedge clk) disable iff (rst)
    (mode16Cap && !regRdData[BIT_CMPA]) |=> !regRdData[BIT_CMPA]);

  // R6: 16-bit match sets compare A in 16-bit compare mode
  a_r6_wide_match: assert property (@(posedge clk) disable iff (rst)
    (mode16Cmp && !mode16Cap && cmp16Evt) |=> regRdData[BIT_CMPA]);

  // R1: upper bits never read as one
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    regRdData[7:4] == 4'h0);

  // R9: no request without its flag and the global enable
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~regRdData[3:0]) == 4'h0) && (globalIe || irq == 4'h0));
endmodule

// File: tb/timerFlags_tb.sv
module timerFlags_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic ovfEvt, cmpAEvt, cmpBEvt, cmp16Evt, capEvt;
  logic mode16Cmp, mode16Cap, regWrEn, globalIe;
  logic [7:0] regWrData, regRdData;
  logic [3:0] ackVec, intEnable, irq;

  int checks = 0;
  int errors = 0;
  logic [3:0] expFlags;
  bit done = 1'b0;

  always #5 clk = ~clk;

  timerFlags dut_i (
    .clk(clk), .rst(rst), .ovfEvt(ovfEvt), .cmpAEvt(cmpAEvt), .cmpBEvt(cmpBEvt),
    .cmp16Evt(cmp16Evt), .capEvt(capEvt), .mode16Cmp(mode16Cmp), .mode16Cap(mode16Cap),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .ackVec(ackVec), .intEnable(intEnable), .globalIe(globalIe), .irq(irq)
  );

  function automatic logic [3:0] modelNext(logic [3:0] cur);
    logic [3:0] setM, clrM;
    setM[0] = ovfEvt;
    setM[1] = mode16Cap ? 1'b0 : (mode16Cmp ? cmp16Evt : cmpAEvt);
    setM[2] = cmpBEvt & ~mode16Cmp & ~mode16Cap;
    setM[3] = capEvt;
    clrM = (regWrEn ? regWrData[3:0] : 4'h0) | ackVec;
    return (cur & ~clrM) | setM;
  endfunction

  function automatic logic [3:0] modelIrq(logic [3:0] f);
    return globalIe ? (f & intEnable) : 4'h0;
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {ovfEvt, cmpAEvt, cmpBEvt, cmp16Evt, capEvt} = '0;
    regWrEn = 1'b0; regWrData = 8'h00; ackVec = 4'h0;
  endtask

  // inputs already driven at a falling edge; check irq, then flags one edge later
  task automatic step(string tag);
    logic [3:0] nxt;
    #1;
    check8({tag, " irq"}, {4'h0, irq}, {4'h0, modelIrq(expFlags)});
    nxt = modelNext(expFlags);
    @(negedge clk);
    expFlags = nxt;
    check8({tag, " flags"}, regRdData, {4'h0, expFlags});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'h1F2E3D);
    idle();
    mode16Cmp = 0; mode16Cap = 0; globalIe = 1; intEnable = 4'hF;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expFlags = 4'h0;
    check8("R1 reset", regRdData, 8'h00);

    // R4 R8 set in normal mode
    ovfEvt = 1; capEvt = 1; step("R4 R8 set");
    idle();
    // R6 normal mode: 8-bit A strobe sets, 16-bit strobe ignored
    cmp16Evt = 1; step("R6 wide ignored");
    idle(); cmpAEvt = 1; cmpBEvt = 1; step("R6 narrow A");
    // R2 write zero and upper bits have no effect
    idle(); regWrEn = 1; regWrData = 8'hF0; step("R2 write zero");
    // R2 write one clears bit 1 only
    idle(); regWrEn = 1; regWrData = 8'h02; step("R2 w1c");
    // R3 acknowledge clears overflow
    idle(); ackVec = 4'h1; step("R3 ack");
    // R9 masking
    idle(); globalIe = 0; step("R9 global off");
    idle(); globalIe = 1; intEnable = 4'h4; step("R9 enable");
    intEnable = 4'hF;
    // R10 set beats write and ack
    idle(); ovfEvt = 1; regWrEn = 1; regWrData = 8'h01; ackVec = 4'h1; step("R10 set wins");
    // clear all
    idle(); regWrEn = 1; regWrData = 8'hFF; step("R2 clear all");
    // R5 R6 16-bit compare mode
    idle(); mode16Cmp = 1; cmpBEvt = 1; cmpAEvt = 1; step("R5 R6 wide mode");
    idle(); cmp16Evt = 1; step("R6 wide match");
    // R7 R5 capture mode, also with compare mode on
    idle(); ackVec = 4'hF; step("R3 ack all");
    idle(); mode16Cap = 1; cmpAEvt = 1; cmpBEvt = 1; cmp16Evt = 1; capEvt = 1; step("R7 R5 R8 capture");
    idle(); mode16Cmp = 0; cmpAEvt = 1; cmpBEvt = 1; step("R7 capture only");
    idle(); mode16Cap = 0;

    // random traffic across all modes, checked against the model
    for (int n = 0; n < 3000; n++) begin
      ovfEvt    = ($urandom % 5) == 0;
      cmpAEvt   = ($urandom % 4) == 0;
      cmpBEvt   = ($urandom % 4) == 0;
      cmp16Evt  = ($urandom % 4) == 0;
      capEvt    = ($urandom % 5) == 0;
      mode16Cmp = $urandom % 2;
      mode16Cap = ($urandom % 3) == 0;
      regWrEn   = ($urandom % 3) == 0;
      regWrData = 8'($urandom);
      ackVec    = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      intEnable = 4'($urandom);
      globalIe  = ($urandom % 4) != 0;
      step("R1 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule